// File: doc/BRIEF.md
# Double-Indirect Post-Indexed Address Sequencer

This block produces the effective address for an addressing mode with two levels of indirection, for an 8-bit processor with a 16-bit address space. A zero-page operand byte names a two-byte location that holds the base of a table of two-byte pointers. The X index selects one entry of that table. The pointer held in that entry has Y added to it, and the sum is the effective address. The block issues the memory reads it needs on a byte-wide read port and reports the result with a one-cycle done strobe.

With the narrow index mode (the default), only the low byte of each index is used. X is doubled so that any of 256 table entries can be reached. With the wide index mode, the full 16-bit X is added without scaling, as a byte offset into the table, and the full 16-bit Y is added to the pointer. A request is taken when `start` is high while the block is idle. Each read is accepted in a cycle where `rd_req` and `rd_ready` are both high, and `rd_data` carries the byte in that same cycle.

States: IDLE waits for `start` (IDLE→BASE_LO). BASE_LO reads the low byte of the table base (→BASE_HI on ready). BASE_HI reads its high byte (→ENT_LO on ready). ENT_LO reads the low byte of the selected entry (→ENT_HI on ready). ENT_HI reads the entry's high byte (→DONE on ready). DONE raises `done` for one cycle (→IDLE unconditionally). Every read state holds while `rd_ready` is low.

Top module: `dind_addr_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `rd_req` and `done` are low and `eff_addr` is 0x0000.
- R2: The first two reads go to page zero: address {0x00, operand} and then {0x00, (operand+1) mod 256}, so operand 0xFF wraps to 0x0000.
- R3: In narrow mode (`wide_idx`=0) the third read address is table base + 2×X[7:0], a full 16-bit add with carry. The fourth read address is that value + 1, modulo 65536. X[15:8] has no effect.
- R4: In wide mode (`wide_idx`=1) the third read address is table base + X[15:0], unscaled. The fourth read address is that value + 1.
- R5: `eff_addr` = entry pointer + Y, modulo 65536. Y is Y[7:0] zero-extended in narrow mode and Y[15:0] in wide mode.
- R6: All pointers are little-endian: the byte read from the lower address is the low byte.
- R7: Exactly four reads are accepted per request. With `rd_ready` held high, `done` is seen five cycles after the cycle in which `start` is sampled.
- R8: `done` is high for exactly one cycle. `eff_addr` keeps its value from that cycle until the next `done`.
- R9: While `rd_req` is high and `rd_ready` is low, the state and `rd_addr` are held.
- R10: `start` has no effect while `busy` is high. The operand and indices are sampled only when `start` is seen in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address computation (taken in IDLE only) |
| zp_op | input | 8 | Zero-page operand byte |
| idx_x | input | 16 | X index (low byte only in narrow mode) |
| idx_y | input | 16 | Y index (low byte only in narrow mode) |
| wide_idx | input | 1 | 1 = 16-bit index mode, X unscaled |
| rd_req | output | 1 | Read request |
| rd_addr | output | 16 | Read address |
| rd_ready | input | 1 | Memory accepts the read this cycle |
| rd_data | input | 8 | Read data, valid when accepted |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion strobe |
| eff_addr | output | 16 | Effective address |

## Verification
A plain narrow case checks that X is doubled and Y is added. A case with operand 0xFF shows that the second base byte wraps within page zero. A narrow case with X=0xFF and a table base near the top of a page shows the carry into the high byte of the entry address. Upper index bits are set in narrow mode to show they are ignored. A wide case gives an X that would produce a different address if it were scaled. A pointer of 0xFFF0 with Y=0x20 shows the wrap of the final add. A run with random `rd_ready` stalls shows that the address is held while stalled. Changed operands presented with `start` during a request show that inputs are sampled only in IDLE.

// File: rtl/dind_pkg.sv
package dind_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_BASE_LO = 3'd1,
        ST_BASE_HI = 3'd2,
        ST_ENT_LO  = 3'd3,
        ST_ENT_HI  = 3'd4,
        ST_DONE    = 3'd5
    } seq_state_t;
endpackage

// File: rtl/dind_offset_gen.sv
module dind_offset_gen #(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic [AW-1:0] x_in,
    input  logic [AW-1:0] y_in,
    input  logic          wide,
    output logic [AW-1:0] x_off,
    output logic [AW-1:0] y_off
);
    localparam int PADX = AW - DW - 1;
    localparam int PADY = AW - DW;

    logic [AW-1:0] x_narrow;
    logic [AW-1:0] y_narrow;

    // narrow: entry size of two bytes, so the low index byte is doubled
    assign x_narrow = {{PADX{1'b0}}, x_in[DW-1:0], 1'b0};
    assign y_narrow = {{PADY{1'b0}}, y_in[DW-1:0]};

    assign x_off = wide ? x_in : x_narrow;
    assign y_off = wide ? y_in : y_narrow;
endmodule

// File: rtl/dind_fsm.sv
module dind_fsm
    import dind_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rd_ready,
    output seq_state_t state,
    output logic       rd_req,
    output logic       busy,
    output logic       done
);
    seq_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start)    nxt = ST_BASE_LO;
            ST_BASE_LO: if (rd_ready) nxt = ST_BASE_HI;
            ST_BASE_HI: if (rd_ready) nxt = ST_ENT_LO;
            ST_ENT_LO:  if (rd_ready) nxt = ST_ENT_HI;
            ST_ENT_HI:  if (rd_ready) nxt = ST_DONE;
            ST_DONE:                  nxt = ST_IDLE;
            default:                  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_req = 1'b0;
        done   = 1'b0;
        busy   = (state != ST_IDLE);
        unique case (state)
            ST_BASE_LO, ST_BASE_HI, ST_ENT_LO, ST_ENT_HI: rd_req = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dind_addr_path.sv
module dind_addr_path
    import dind_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_state_t    state,
    input  logic          start,
    input  logic          rd_ready,
    input  logic [DW-1:0] zp_op,
    input  logic [AW-1:0] x_off,
    input  logic [AW-1:0] y_off,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] eff_addr
);
    localparam int HIW = AW - DW;

    logic [DW-1:0] zp_q;
    logic [DW-1:0] zp_nxt;
    logic [AW-1:0] xoff_q;
    logic [AW-1:0] yoff_q;
    logic [DW-1:0] base_lo_q;
    logic [DW-1:0] ptr_lo_q;
    logic [AW-1:0] ent_q;
    logic [AW-1:0] eff_q;

    assign zp_nxt = zp_q + DW'(1);   // wraps within page zero

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zp_q      <= '0;
            xoff_q    <= '0;
            yoff_q    <= '0;
            base_lo_q <= '0;
            ptr_lo_q  <= '0;
            ent_q     <= '0;
            eff_q     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    zp_q   <= zp_op;
                    xoff_q <= x_off;
                    yoff_q <= y_off;
                end
                ST_BASE_LO: if (rd_ready) base_lo_q <= rd_data;
                ST_BASE_HI: if (rd_ready) ent_q <= {rd_data, base_lo_q} + xoff_q;
                ST_ENT_LO:  if (rd_ready) ptr_lo_q <= rd_data;
                ST_ENT_HI:  if (rd_ready) eff_q <= {rd_data, ptr_lo_q} + yoff_q;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_BASE_LO: rd_addr = {{HIW{1'b0}}, zp_q};
            ST_BASE_HI: rd_addr = {{HIW{1'b0}}, zp_nxt};
            ST_ENT_LO:  rd_addr = ent_q;
            ST_ENT_HI:  rd_addr = ent_q + AW'(1);
            default:    rd_addr = '0;
        endcase
    end

    assign eff_addr = eff_q;
endmodule

// File: rtl/dind_addr_seq.sv
module dind_addr_seq
    import dind_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] zp_op,
    input  logic [AW-1:0] idx_x,
    input  logic [AW-1:0] idx_y,
    input  logic          wide_idx,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ready,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] eff_addr
);
    seq_state_t    state;
    logic [AW-1:0] x_off;
    logic [AW-1:0] y_off;

    dind_offset_gen #(.DW(DW), .AW(AW)) u_off (
        .x_in (idx_x),
        .y_in (idx_y),
        .wide (wide_idx),
        .x_off(x_off),
        .y_off(y_off)
    );

    dind_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .rd_ready(rd_ready),
        .state   (state),
        .rd_req  (rd_req),
        .busy    (busy),
        .done    (done)
    );

    dind_addr_path #(.DW(DW), .AW(AW)) u_path (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .start   (start),
        .rd_ready(rd_ready),
        .zp_op   (zp_op),
        .x_off   (x_off),
        .y_off   (y_off),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .eff_addr(eff_addr)
    );
endmodule

// File: rtl/dind_addr_seq_chk.sv
module dind_addr_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          rd_req,
    input logic          rd_ready,
    input logic [AW-1:0] rd_addr,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] eff_addr
);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_eff_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(eff_addr));

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));

    p_no_read_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req);

    p_read_only_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);

    p_done_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_page_zero_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (rd_req && rd_addr[AW-1:8] == '0));
endmodule

bind dind_addr_seq dind_addr_seq_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .rd_req  (rd_req),
    .rd_ready(rd_ready),
    .rd_addr (rd_addr),
    .busy    (busy),
    .done    (done),
    .eff_addr(eff_addr)
);

// File: tb/dind_addr_seq_test.sv
module dind_addr_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  zp_op = '0;
    logic [15:0] idx_x = '0;
    logic [15:0] idx_y = '0;
    logic        wide_idx = 1'b0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_ready = 1'b1;
    logic [7:0]  rd_data;
    logic        busy;
    logic        done;
    logic [15:0] eff_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit stall_en = 1'b0;

    logic [15:0] pa [8];
    logic [7:0]  pd [8];
    logic        pv [8];
    logic [15:0] rlog [8];
    int          rcnt = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;   // 125 MHz

    dind_addr_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .zp_op(zp_op),
        .idx_x(idx_x), .idx_y(idx_y), .wide_idx(wide_idx),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_data(rd_data), .busy(busy), .done(done), .eff_addr(eff_addr)
    );

    function automatic logic [7:0] fill(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
    endfunction

    function automatic logic [7:0] model(input logic [15:0] a);
        logic [7:0] d;
        d = fill(a);
        for (int i = 0; i < 8; i++) if (pv[i] && pa[i] == a) d = pd[i];
        return d;
    endfunction

    always_comb begin
        rd_data = fill(rd_addr);
        for (int i = 0; i < 8; i++) if (pv[i] && pa[i] == rd_addr) rd_data = pd[i];
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rd_ready <= stall_en ? lfsr[0] : 1'b1;
    end

    always @(negedge clk) begin
        if (rd_req && rd_ready) begin
            if (rcnt < 8) rlog[rcnt] = rd_addr;
            rcnt = rcnt + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_patch();
        for (int i = 0; i < 8; i++) begin pv[i] = 1'b0; pa[i] = '0; pd[i] = '0; end
    endtask

    task automatic patch(input int i, input logic [15:0] a, input logic [7:0] d);
        pv[i] = 1'b1; pa[i] = a; pd[i] = d;
    endtask

    // runs one request; optionally presents changed inputs with start while busy
    task automatic run_case(input string req, input logic [7:0] zp,
                            input logic [15:0] x, input logic [15:0] y,
                            input bit wide, input bit poke);
        logic [15:0] base, ent, ptr, eff_exp, xo, yo, held;
        logic [7:0]  zp1;
        int n;
        zp1  = zp + 8'd1;
        base = {model({8'h00, zp1}), model({8'h00, zp})};
        xo   = wide ? x : {7'd0, x[7:0], 1'b0};
        yo   = wide ? y : {8'd0, y[7:0]};
        ent  = base + xo;
        ptr  = {model(ent + 16'd1), model(ent)};
        eff_exp = ptr + yo;

        @(negedge clk);
        rcnt = 0;
        zp_op = zp; idx_x = x; idx_y = y; wide_idx = wide; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 200) begin
            if (poke && n == 2) begin
                zp_op = ~zp; idx_x = x ^ 16'h0F0F; idx_y = ~y; wide_idx = ~wide; start = 1'b1;
            end else start = 1'b0;
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(req, "done seen", {31'd0, done}, 32'd1);
        if (!stall_en) chk("R7", "cycles start to done", n, 5);
        chk("R7", "read count", rcnt, 4);
        chk("R2", "read 1 addr", {16'd0, rlog[0]}, {24'd0, zp});
        chk("R2", "read 2 addr", {16'd0, rlog[1]}, {24'd0, zp1});
        chk(wide ? "R4" : "R3", "read 3 addr", {16'd0, rlog[2]}, {16'd0, ent});
        chk(wide ? "R4" : "R3", "read 4 addr", {16'd0, rlog[3]}, {16'd0, ent + 16'd1});
        chk(req, "eff_addr", {16'd0, eff_addr}, {16'd0, eff_exp});
        held = eff_addr;
        zp_op = 8'h00; idx_x = '0; idx_y = '0;
        @(negedge clk);
        chk("R8", "done one cycle", {31'd0, done}, 32'd0);
        @(negedge clk);
        chk("R8", "eff_addr held", {16'd0, eff_addr}, {16'd0, held});
        chk("R8", "idle after done", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1", "busy", {31'd0, busy}, 32'd0);
        chk("R1", "rd_req", {31'd0, rd_req}, 32'd0);
        chk("R1", "done", {31'd0, done}, 32'd0);
        chk("R1", "eff_addr", {16'd0, eff_addr}, 32'd0);
    endtask

    task automatic t_basic();      // R5 R6 little-endian pointer and Y add
        clear_patch();
        patch(0, 16'h0010, 8'h34); patch(1, 16'h0011, 8'h12);
        patch(2, 16'h123A, 8'hCD); patch(3, 16'h123B, 8'hAB);
        run_case("R6", 8'h10, 16'h0003, 16'h0005, 1'b0, 1'b0);
        chk("R5", "eff value", {16'd0, eff_addr}, 32'h0000ABD2);
    endtask

    task automatic t_zp_wrap();    // R2
        clear_patch();
        run_case("R2", 8'hFF, 16'h0011, 16'h0022, 1'b0, 1'b0);
    endtask

    task automatic t_scale_carry(); // R3 carry and ignored high X/Y bits
        clear_patch();
        patch(0, 16'h0020, 8'hF0); patch(1, 16'h0021, 8'h12);
        run_case("R3", 8'h20, 16'hAAFF, 16'h7701, 1'b0, 1'b0);
        chk("R3", "entry carry addr", {16'd0, rlog[2]}, 32'h000014EE);
    endtask

    task automatic t_wide();        // R4
        clear_patch();
        patch(0, 16'h0030, 8'h00); patch(1, 16'h0031, 8'h20);
        run_case("R4", 8'h30, 16'h0123, 16'h0200, 1'b1, 1'b0);
        chk("R4", "unscaled entry addr", {16'd0, rlog[2]}, 32'h00002123);
    endtask

    task automatic t_eff_wrap();    // R5
        clear_patch();
        patch(0, 16'h0040, 8'h00); patch(1, 16'h0041, 8'h30);
        patch(2, 16'h3000, 8'hF0); patch(3, 16'h3001, 8'hFF);
        run_case("R5", 8'h40, 16'h0000, 16'h0020, 1'b0, 1'b0);
        chk("R5", "wrapped eff", {16'd0, eff_addr}, 32'h00000010);
    endtask

    task automatic t_stall();       // R9
        clear_patch();
        stall_en = 1'b1;
        run_case("R9", 8'h5A, 16'h0081, 16'h00F3, 1'b0, 1'b0);
        run_case("R9", 8'hC3, 16'h8001, 16'hFF00, 1'b1, 1'b0);
        stall_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_busy_start();  // R10
        clear_patch();
        run_case("R10", 8'h66, 16'h0007, 16'h0009, 1'b0, 1'b1);
    endtask

    initial begin
        clear_patch();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_zp_wrap();
        t_scale_carry();
        t_wide();
        t_eff_wrap();
        t_stall();
        t_busy_start();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule